// File: doc/BRIEF.md
# Guarded Delayed-Branch Program Sequencer

This block produces the fetch address of a wide-issue core that starts one long instruction per clock. The program counter moves forward by one instruction step on every cycle that is not stalled. The issue stage offers jump operations to the block. Each jump carries a guard bit taken from a general register, a condition bit, a target address and a two-bit kind. A jump is taken only when its guard is true and its kind's condition holds.

A taken jump does not redirect at once. The instructions that issue in the next `DELAY_SLOTS` non-stalled cycles (three by default) always execute. The target becomes the fetch PC in the cycle after the last of them. A jump taken inside the delay slots of an earlier jump waits in a small in-order pending queue. Each queued jump redirects its own fixed number of issue cycles after it was taken, so redirects happen in issue order.

Branch offers use a valid/ready pair. An offer is consumed only in a cycle where `br_valid_i` and `br_ready_o` are both high. `br_ready_o` drops while `stall_i` is high, and offers made during a stall are discarded rather than held. No instruction issues in a stalled cycle. The PC is frozen and no delay slot is counted. A one-cycle `redirect_o` strobe marks each cycle in which the PC has just been loaded with a jump target.

Top module: `guarded_seq`

## Requirements
- R1: Synchronous reset sets `pc_o` to `RESET_VEC`, clears `redirect_o` and drops every pending jump, so a jump taken just before reset never redirects afterwards.
- R2: In each non-stalled cycle with no redirect due, `pc_o` advances by `PC_STEP` (default 1) at the next clock edge.
- R3: While `stall_i` is high, `br_ready_o` is low, `pc_o` holds its value, delay slots are not counted, and a jump offered in that cycle is ignored.
- R4: Kind 2'b00 (guarded always) is taken exactly when the guard bit is 1.
- R5: Kind 2'b01 (jump if true) is taken exactly when the guard bit is 1 and the condition bit is 1.
- R6: Kind 2'b10 (jump if false) is taken exactly when the guard bit is 1 and the condition bit is 0.
- R7: Kind 2'b11 is reserved and is never taken.
- R8: Suppose a jump is taken in the cycle where `pc_o` is P. With no stalls, the next three cycles show P+1, P+2 and P+3, and the cycle after them shows the target.
- R9: `redirect_o` is high only in the cycle right after the edge that loaded a jump target into `pc_o`, and low in the cycles that follow a sequential step.
- R10: Jumps taken on consecutive issue cycles, up to `DELAY_SLOTS` of them, are all kept. They redirect in issue order, each `DELAY_SLOTS` issue cycles after it was taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| stall_i | input | 1 | Freeze issue, PC and delay-slot counting |
| br_valid_i | input | 1 | A jump operation is offered this cycle |
| br_ready_o | output | 1 | Jump offer can be consumed (low during stall) |
| br_kind_i | input | 2 | 00 always, 01 if true, 10 if false, 11 reserved |
| br_guard_i | input | 1 | Guard bit from the guarding register |
| br_cond_i | input | 1 | Condition operand bit |
| br_target_i | input | ADDR_W | Jump target address |
| pc_o | output | ADDR_W | Current fetch PC |
| redirect_o | output | 1 | PC was just loaded with a jump target |

## Verification
The hardest case to reach from the ports is a full pending queue. It needs a taken jump on every issue cycle so that several countdowns overlap, one entry expires and another is pushed on the same edge. A stall dropped into the middle of a delay-slot window is also hard to reach, because the countdown must stretch without losing its place. The stimulus table drives three taken jumps back to back and holds a stall inside an open delay window. A directed sequence asserts reset while a jump is still pending and then watches enough cycles to prove that the stale target never shows up.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [1:0] {
    BK_ALWAYS   = 2'b00,
    BK_IF_SET   = 2'b01,
    BK_IF_CLEAR = 2'b10,
    BK_NONE     = 2'b11
  } br_kind_e;

  function automatic int cnt_width(input int slots);
    return (slots > 1) ? $clog2(slots) : 1;
  endfunction

endpackage

// File: rtl/br_decide.sv
module br_decide
  import seq_pkg::*;
(
  input  logic       valid_i,
  input  logic       ready_i,
  input  logic [1:0] kind_i,
  input  logic       guard_i,
  input  logic       cond_i,
  output logic       taken_o
);

  br_kind_e kind;
  logic     cond_ok;

  always_comb begin
    kind = br_kind_e'(kind_i);
    unique case (kind)
      BK_ALWAYS:   cond_ok = 1'b1;
      BK_IF_SET:   cond_ok = cond_i;
      BK_IF_CLEAR: cond_ok = ~cond_i;
      default:     cond_ok = 1'b0;
    endcase
  end

  assign taken_o = valid_i & ready_i & guard_i & cond_ok;

endmodule

// File: rtl/br_pend_q.sv
module br_pend_q
  import seq_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DELAY_SLOTS = 3
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              adv_i,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] push_tgt_i,
  output logic              expire_o,
  output logic [ADDR_W-1:0] head_tgt_o
);

  localparam int DEPTH = DELAY_SLOTS;
  localparam int CNT_W = cnt_width(DELAY_SLOTS);
  localparam int OCC_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] INIT_CNT = CNT_W'(DELAY_SLOTS - 1);

  logic [ADDR_W-1:0] tgt_q [DEPTH];
  logic [CNT_W-1:0]  cnt_q [DEPTH];
  logic [OCC_W-1:0]  occ_q;

  logic [ADDR_W-1:0] tgt_d [DEPTH];
  logic [CNT_W-1:0]  cnt_d [DEPTH];
  logic [OCC_W-1:0]  occ_d;
  logic [OCC_W-1:0]  push_idx;
  logic              pop;

  assign pop        = adv_i && (occ_q != '0) && (cnt_q[0] == '0);
  assign expire_o   = pop;
  assign head_tgt_o = tgt_q[0];
  assign push_idx   = occ_q - OCC_W'(pop);

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      tgt_d[i] = tgt_q[i];
      cnt_d[i] = cnt_q[i];
    end
    for (int i = 0; i < DEPTH; i++) begin
      int src;
      src = i + int'(pop);
      if (src < int'(occ_q) && src < DEPTH) begin
        tgt_d[i] = tgt_q[src];
        cnt_d[i] = adv_i ? (cnt_q[src] - 1'b1) : cnt_q[src];
      end
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (push_i && i == int'(push_idx)) begin
        tgt_d[i] = push_tgt_i;
        cnt_d[i] = INIT_CNT;
      end
    end
    occ_d = push_idx + OCC_W'(push_i);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      occ_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        tgt_q[i] <= '0;
        cnt_q[i] <= '0;
      end
    end else begin
      occ_q <= occ_d;
      for (int i = 0; i < DEPTH; i++) begin
        tgt_q[i] <= tgt_d[i];
        cnt_q[i] <= cnt_d[i];
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (rst_i)
    (push_i && !pop) |-> (int'(occ_q) < DEPTH)); // R10

  generate
    if (DEPTH > 1) begin : g_order
      AST_HEAD_ORDER: assert property (@(posedge clk_i) disable iff (rst_i)
        (int'(occ_q) >= 2) |-> (cnt_q[0] < cnt_q[1])); // R10
    end
  endgenerate

endmodule

// File: rtl/pc_reg.sv
module pc_reg #(
  parameter int              ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] RESET_VEC = '0,
  parameter int              PC_STEP   = 1
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              adv_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_tgt_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic              redirect_o
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(PC_STEP);

  logic [ADDR_W-1:0] pc_q;
  logic              redir_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pc_q    <= RESET_VEC;
      redir_q <= 1'b0;
    end else if (adv_i) begin
      pc_q    <= load_i ? load_tgt_i : (pc_q + STEP);
      redir_q <= load_i;
    end else begin
      redir_q <= 1'b0;
    end
  end

  assign pc_o       = pc_q;
  assign redirect_o = redir_q;

  AST_STALL_FREEZE: assert property (@(posedge clk_i) disable iff (rst_i)
    !adv_i |=> $stable(pc_q)); // R3

  AST_SEQ_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
    (adv_i && !load_i) |=> (pc_q == $past(pc_q) + STEP)); // R2

endmodule

// File: rtl/guarded_seq.sv
module guarded_seq
  import seq_pkg::*;
#(
  parameter int                ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] RESET_VEC   = '0,
  parameter int                PC_STEP     = 1,
  parameter int                DELAY_SLOTS = 3
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              stall_i,
  input  logic              br_valid_i,
  output logic              br_ready_o,
  input  logic [1:0]        br_kind_i,
  input  logic              br_guard_i,
  input  logic              br_cond_i,
  input  logic [ADDR_W-1:0] br_target_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic              redirect_o
);

  logic              adv;
  logic              taken;
  logic              expire;
  logic [ADDR_W-1:0] head_tgt;

  assign adv        = ~stall_i;
  assign br_ready_o = adv;

  br_decide u_decide (
    .valid_i (br_valid_i),
    .ready_i (br_ready_o),
    .kind_i  (br_kind_i),
    .guard_i (br_guard_i),
    .cond_i  (br_cond_i),
    .taken_o (taken)
  );

  br_pend_q #(
    .ADDR_W      (ADDR_W),
    .DELAY_SLOTS (DELAY_SLOTS)
  ) u_pend (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .adv_i      (adv),
    .push_i     (taken),
    .push_tgt_i (br_target_i),
    .expire_o   (expire),
    .head_tgt_o (head_tgt)
  );

  pc_reg #(
    .ADDR_W    (ADDR_W),
    .RESET_VEC (RESET_VEC),
    .PC_STEP   (PC_STEP)
  ) u_pc (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .adv_i      (adv),
    .load_i     (expire),
    .load_tgt_i (head_tgt),
    .pc_o       (pc_o),
    .redirect_o (redirect_o)
  );

  AST_TAKEN_NEEDS_READY: assert property (@(posedge clk_i) disable iff (rst_i)
    taken |-> !stall_i); // R3

  AST_REDIR_AFTER_ADV: assert property (@(posedge clk_i) disable iff (rst_i)
    redirect_o |-> $past(!stall_i)); // R9

endmodule

// File: tb/sim_guarded_seq.sv
module sim_guarded_seq;

  localparam int          CLK_PERIOD = 10;
  localparam int          ADDR_W     = 32;
  localparam logic [31:0] RVEC       = 32'h0000_0100;
  localparam int          NROWS      = 31;

  // {stall, valid, kind[2], guard, cond, target[16], exp_pc[16], exp_redir}
  localparam logic [38:0] VEC [NROWS] = '{
    {1'b0,1'b0,2'd0,1'b0,1'b0,16'h0000,16'h0100,1'b0}, // 0 R1 R2
    {1'b0,1'b1,2'd0,1'b1,1'b0,16'h0200,16'h0101,1'b0}, // 1 R4 taken
    {1'b0,1'b0,2'd0,1'b0,1'b0,16'h0000,16'h0102,1'b0}, // 2 R8 slot
    {1'b0,1'b0,2'd0,1'b0,1'b0,16'h0000,16'h0103,1'b0}, // 3 R8 slot
    {1'b0,1'b0,2'd0,1'b0,1'b0,16'h0000,16'h0104,1'b0}, // 4 R8 slot
    {1'b0,1'b0,2'd0,1'b0,1'b0,16'h0000,16'h0200,1'b1}, // 5 R8 R9
    {1'b0,1'b1,2'd1,1'b1,1'b1,16'h0300,16'h0201,1'b0}, // 6 R5 taken
    {1'b1,1'b0,2'd0,1'b0,1'b0,16'h0000,16'h0202,1'b0}, // 7 R3 stall
    {1'b0,1'b0,2'd0,1'b0,1'b0,16'h0000,16'h0202,1'b0}, // 8 R3 held
    {1'b0,1'b0,2'd0,1'b0,1'b0,16'h0000,16'h0203,1'b0}, // 9
    {1'b0,1'b0,2'd0,1'b0,1'b0,16'h0000,16'h0204,1'b0}, // 10
    {1'b0,1'b1,2'd2,1'b1,1'b0,16'h0400,16'h0300,1'b1}, // 11 R6 taken
    {1'b0,1'b1,2'd1,1'b1,1'b0,16'h0999,16'h0301,1'b0}, // 12 R5 not
    {1'b0,1'b1,2'd3,1'b1,1'b1,16'h0999,16'h0302,1'b0}, // 13 R7 not
    {1'b0,1'b1,2'd0,1'b0,1'b1,16'h0999,16'h0303,1'b0}, // 14 R4 not
    {1'b0,1'b1,2'd2,1'b1,1'b1,16'h0999,16'h0400,1'b1}, // 15 R6 not
    {1'b0,1'b0,2'd0,1'b0,1'b0,16'h0000,16'h0401,1'b0}, // 16 R9 low
    {1'b0,1'b1,2'd0,1'b1,1'b0,16'h0500,16'h0402,1'b0}, // 17 R10
    {1'b0,1'b1,2'd0,1'b1,1'b0,16'h0600,16'h0403,1'b0}, // 18 R10
    {1'b0,1'b1,2'd0,1'b1,1'b0,16'h0700,16'h0404,1'b0}, // 19 R10
    {1'b0,1'b0,2'd0,1'b0,1'b0,16'h0000,16'h0405,1'b0}, // 20
    {1'b0,1'b0,2'd0,1'b0,1'b0,16'h0000,16'h0500,1'b1}, // 21 R10
    {1'b0,1'b0,2'd0,1'b0,1'b0,16'h0000,16'h0600,1'b1}, // 22 R10
    {1'b0,1'b0,2'd0,1'b0,1'b0,16'h0000,16'h0700,1'b1}, // 23 R10
    {1'b1,1'b1,2'd0,1'b1,1'b0,16'h0999,16'h0701,1'b0}, // 24 R3 ignored
    {1'b0,1'b0,2'd0,1'b0,1'b0,16'h0000,16'h0701,1'b0}, // 25
    {1'b0,1'b0,2'd0,1'b0,1'b0,16'h0000,16'h0702,1'b0}, // 26
    {1'b0,1'b0,2'd0,1'b0,1'b0,16'h0000,16'h0703,1'b0}, // 27
    {1'b0,1'b0,2'd0,1'b0,1'b0,16'h0000,16'h0704,1'b0}, // 28
    {1'b0,1'b0,2'd0,1'b0,1'b0,16'h0000,16'h0705,1'b0}, // 29
    {1'b0,1'b0,2'd0,1'b0,1'b0,16'h0000,16'h0706,1'b0}  // 30
  };

  logic              clk = 1'b0;
  logic              rst;
  logic              stall;
  logic              br_valid;
  logic              br_ready;
  logic [1:0]        br_kind;
  logic              br_guard;
  logic              br_cond;
  logic [ADDR_W-1:0] br_target;
  logic [ADDR_W-1:0] pc;
  logic              redirect;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  guarded_seq #(
    .ADDR_W      (ADDR_W),
    .RESET_VEC   (RVEC),
    .PC_STEP     (1),
    .DELAY_SLOTS (3)
  ) u0 (
    .clk_i       (clk),
    .rst_i       (rst),
    .stall_i     (stall),
    .br_valid_i  (br_valid),
    .br_ready_o  (br_ready),
    .br_kind_i   (br_kind),
    .br_guard_i  (br_guard),
    .br_cond_i   (br_cond),
    .br_target_i (br_target),
    .pc_o        (pc),
    .redirect_o  (redirect)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    stall     = 1'b0;
    br_valid  = 1'b0;
    br_kind   = 2'd0;
    br_guard  = 1'b0;
    br_cond   = 1'b0;
    br_target = '0;
  endtask

  initial begin
    rst = 1'b1;
    idle_inputs();
    repeat (3) @(negedge clk);
    check("R1 reset pc", pc, RVEC);
    check("R1 reset redirect", {31'd0, redirect}, 32'd0);

    for (int i = 0; i < NROWS; i++) begin
      logic [38:0] v;
      string       tag;
      @(negedge clk);
      if (i == 0) rst = 1'b0;
      v   = VEC[i];
      tag = $sformatf("R8/R10 row %0d pc", i);
      check(tag, pc, {16'd0, v[16:1]});
      tag = $sformatf("R9 row %0d redirect", i);
      check(tag, {31'd0, redirect}, {31'd0, v[0]});
      stall     = v[38];
      br_valid  = v[37];
      br_kind   = v[36:35];
      br_guard  = v[34];
      br_cond   = v[33];
      br_target = {16'd0, v[32:17]};
    end

    // R3: ready follows stall
    @(negedge clk);
    idle_inputs();
    stall = 1'b1;
    #1 check("R3 ready low in stall", {31'd0, br_ready}, 32'd0);
    @(negedge clk);
    stall = 1'b0;
    #1 check("R3 ready high", {31'd0, br_ready}, 32'd1);

    // R1: reset while a jump is pending
    @(negedge clk);
    br_valid  = 1'b1;
    br_kind   = 2'd0;
    br_guard  = 1'b1;
    br_target = 32'h0000_0999;
    @(negedge clk);
    idle_inputs();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 pc after mid reset", pc, RVEC);
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      check("R1 pending cleared pc", pc, RVEC + 32'(k));
      check("R1 pending cleared redirect", {31'd0, redirect}, 32'd0);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule